// File: doc/BRIEF.md
# Tick Counter with Three Compare Interrupts

This block is a free-running 32-bit up-counter. It advances by one on each pulse of a 32 kHz tick enable, which is supplied as a single-cycle strobe in the system clock domain. Software reaches it through a simple word-wide register port. A count is preloaded at one offset and the live count is read back at a different offset. Three compare registers each watch the count. When a counted tick brings the count onto a compare value, that compare's pending flag is set. The single interrupt output is the OR of the three flags.

A shared control word carries two gates: a counter-enable bit and an oscillator-enable bit. The counter and all compares run only while both bits are set. A pending flag is cleared by writing its compare register again, with the same value or a new one. Read data is registered: a read request presented in one cycle returns its data on `bus_rdata` after the next rising clock edge. Reset is asynchronous and active-low. It is released synchronously inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `tick_cmp_timer`

## Requirements
- R1: While control bits 13 and 8 are both set, each cycle with `tick_en` high and no preload write adds one to the count.
- R2: A write to offset 0x64 loads the count with the written word and overrides a tick in the same cycle. A read of offset 0x68 returns the count, valid on `bus_rdata` after the clock edge that samples the request.
- R3: While control bit 13 (counter enable) is clear, ticks leave the count unchanged and set no pending flag.
- R4: While control bit 8 (oscillator enable) is clear, ticks leave the count unchanged and set no pending flag, even when bit 13 is set.
- R5: Compare registers sit at offsets 0x6C, 0x70 and 0x74. Each one sets its own pending flag on a counted tick that makes the count equal to its value. `irq` is high while any flag is set.
- R6: A write to a compare register clears that compare's pending flag. The clear wins over a set in the same cycle.
- R7: After reset the count is 0, all three compare registers read 0, the control word reads 0 and `irq` is low.
- R8: A flag is set only by a counted tick. Preloading the count to a compare value does not set it, and neither does the count staying equal to the compare value.
- R9: The count wraps from 0xFFFFFFFF to 0 with no other event. A compare value of 0 matches on that wrap.
- R10: Compare registers read back what was written. The control offset 0x40 reads back only bits 13 and 8, with all other bits 0. Offset 0x64 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Single-cycle 32 kHz advance strobe |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | OR of the three compare pending flags |

## Verification
The hardest case to reach from the ports is the counter wrap. At the real tick rate it would take more than four billion ticks to get there. The bench preloads the count to 0xFFFFFFFE, sets one compare to 0 and the others to unrelated values, and ticks twice: the first tick must raise nothing and the second must raise the interrupt. The edge-only compare behaviour needs a similar arrangement. The bench clears a flag while the count still equals the compare value, or preloads the count straight onto that value, and then confirms that the interrupt stays low with no tick.

// File: rtl/tctr_pkg.sv
package tctr_pkg;

  localparam logic [7:0] OFS_CTRL     = 8'h40;
  localparam logic [7:0] OFS_LOAD     = 8'h64;
  localparam logic [7:0] OFS_COUNT    = 8'h68;
  localparam logic [7:0] OFS_CMP_BASE = 8'h6C;
  localparam int         CMP_STRIDE   = 4;

  localparam int BIT_CNT_EN = 13;
  localparam int BIT_OSC_EN = 8;

  typedef struct packed {
    logic cnt_en;
    logic osc_en;
  } ctrl_t;

endpackage

// File: rtl/tctr_rst_sync.sv
module tctr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tctr_regs.sv
module tctr_regs
  import tctr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int NUM_CMP = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_req,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  input  logic [DATA_W-1:0]               count,
  output ctrl_t                           ctrl,
  output logic                            load_stb,
  output logic [DATA_W-1:0]               load_val,
  output logic [NUM_CMP-1:0]              cmp_wr,
  output logic [NUM_CMP-1:0][DATA_W-1:0]  cmp_val,
  output logic [DATA_W-1:0]               bus_rdata
);

  function automatic logic [ADDR_W-1:0] cmp_addr(input int idx);
    return ADDR_W'(OFS_CMP_BASE) + ADDR_W'(CMP_STRIDE * idx);
  endfunction

  logic wr_stb, rd_stb;
  assign wr_stb = bus_req &  bus_wr;
  assign rd_stb = bus_req & ~bus_wr;

  // control word
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_we;

  always_comb begin
    ctrl_we       = wr_stb && (bus_addr == ADDR_W'(OFS_CTRL));
    ctrl_d.cnt_en = bus_wdata[BIT_CNT_EN];
    ctrl_d.osc_en = bus_wdata[BIT_OSC_EN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  // preload strobe
  always_comb begin
    load_stb = wr_stb && (bus_addr == ADDR_W'(OFS_LOAD));
    load_val = bus_wdata;
  end

  // compare registers
  logic [NUM_CMP-1:0][DATA_W-1:0] cmp_q;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp_reg
    logic we;
    assign we = wr_stb && (bus_addr == cmp_addr(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cmp_q[g] <= '0;
      else if (we) cmp_q[g] <= bus_wdata;
    end

    assign cmp_wr[g] = we;
  end

  assign cmp_val = cmp_q;

  // registered read path
  logic [DATA_W-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      rd_d[BIT_CNT_EN] = ctrl_q.cnt_en;
      rd_d[BIT_OSC_EN] = ctrl_q.osc_en;
    end
    if (bus_addr == ADDR_W'(OFS_COUNT)) rd_d = count;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (bus_addr == cmp_addr(i)) rd_d = cmp_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_stb) rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;

endmodule

// File: rtl/tctr_counter.sv
module tctr_counter
  import tctr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  ctrl_t             ctrl,
  input  logic              load_stb,
  input  logic [DATA_W-1:0] load_val,
  output logic              run,
  output logic              step,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] count_inc
);
  logic [DATA_W-1:0] count_q, count_d;
  logic              count_en;

  always_comb begin
    run       = ctrl.cnt_en & ctrl.osc_en;
    step      = tick_en & run & ~load_stb;
    count_inc = count_q + DATA_W'(1);
    count_en  = load_stb | step;
    count_d   = load_stb ? load_val : count_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/tctr_cmp_unit.sv
module tctr_cmp_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [DATA_W-1:0] count_inc,
  input  logic [DATA_W-1:0] cmp_val,
  input  logic              clr,
  output logic              pend
);
  logic pend_q, pend_d, hit;

  always_comb begin
    hit    = step && (count_inc == cmp_val);
    pend_d = pend_q;
    if (hit) pend_d = 1'b1;
    if (clr) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tctr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int NUM_CMP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic                           rst_q_n;
  ctrl_t                          ctrl;
  logic                           load_stb;
  logic [DATA_W-1:0]              load_val;
  logic [NUM_CMP-1:0]             cmp_wr;
  logic [NUM_CMP-1:0][DATA_W-1:0] cmp_val;
  logic                           run, step;
  logic [DATA_W-1:0]              count, count_inc;
  logic [NUM_CMP-1:0]             pend;

  tctr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  tctr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count     (count),
    .ctrl      (ctrl),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .cmp_wr    (cmp_wr),
    .cmp_val   (cmp_val),
    .bus_rdata (bus_rdata)
  );

  tctr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .tick_en   (tick_en),
    .ctrl      (ctrl),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .run       (run),
    .step      (step),
    .count     (count),
    .count_inc (count_inc)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    tctr_cmp_unit #(.DATA_W(DATA_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .step      (step),
      .count_inc (count_inc),
      .cmp_val   (cmp_val[g]),
      .clr       (cmp_wr[g]),
      .pend      (pend[g])
    );
  end

  assign irq = |pend;

endmodule

// File: rtl/tctr_chk.sv
module tctr_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_CMP = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic               step,
  input logic               load_stb,
  input logic [DATA_W-1:0]  load_val,
  input logic [DATA_W-1:0]  count,
  input logic [NUM_CMP-1:0] cmp_wr,
  input logic [NUM_CMP-1:0] pend,
  input logic               irq
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (count == $past(count) + DATA_W'(1))); // R1

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (count == $past(load_val))); // R2

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_stb) |=> $stable(count)); // R3

  AST_NO_NEW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ((pend & ~$past(pend)) == '0)); // R8

  AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr != '0) |=> ((pend & $past(cmp_wr)) == '0)); // R6

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq); // R5

endmodule

bind tick_cmp_timer tctr_chk #(.DATA_W(DATA_W), .NUM_CMP(NUM_CMP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .run      (run),
  .step     (step),
  .load_stb (load_stb),
  .load_val (load_val),
  .count    (count),
  .cmp_wr   (cmp_wr),
  .pend     (pend),
  .irq      (irq)
);

// File: tb/tb_tick_cmp_timer.sv
`timescale 1ns/1ps
module tb_tick_cmp_timer;
  localparam logic [7:0] A_CTRL = 8'h40, A_LOAD = 8'h64, A_CNT = 8'h68;
  localparam logic [31:0] RUN_BOTH = 32'h0000_2100;

  logic        clk = 1'b0;
  logic        rst_n, tick_en, bus_req, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tick_cmp_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_req(bus_req),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] cmp_a(input int i);
    return 8'h6C + 8'(4 * i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_req = 0; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CNT, v);  chk("R7 count", v, 0);
    rd(A_CTRL, v); chk("R7 ctrl", v, 0);
    for (int i = 0; i < 3; i++) begin
      rd(cmp_a(i), v); chk("R7 compare", v, 0);
    end
    chk("R7 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_gating();
    logic [31:0] v;
    ticks(3); rd(A_CNT, v); chk("R3 both off", v, 0);
    wr(A_CTRL, 32'h0000_2000); ticks(3);
    rd(A_CNT, v); chk("R4 osc off", v, 0);
    chk("R4 irq", {31'b0, irq}, 0);
    wr(A_CTRL, 32'h0000_0100); ticks(3);
    rd(A_CNT, v); chk("R3 cnt off", v, 0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R10 ctrl readback", v, RUN_BOTH);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(A_LOAD, 100);
    rd(A_CNT, v); chk("R2 preload", v, 100);
    ticks(5);
    rd(A_CNT, v); chk("R1 five ticks", v, 105);
    @(negedge clk); bus_req = 1; bus_wr = 1; bus_addr = A_LOAD; bus_wdata = 500; tick_en = 1;
    @(negedge clk); bus_req = 0; bus_wr = 0; tick_en = 0;
    rd(A_CNT, v); chk("R2 load beats tick", v, 500);
    rd(A_LOAD, v); chk("R10 load offset reads 0", v, 0);
  endtask

  task automatic t_match();
    logic [31:0] v, c;
    for (int i = 0; i < 3; i++) wr(cmp_a(i), 32'hAAAA_0000);
    for (int i = 0; i < 3; i++) begin
      c = 1000 + 32'(10 * i);
      wr(cmp_a(i), c);
      rd(cmp_a(i), v); chk("R10 compare readback", v, c);
      wr(A_LOAD, c - 3);
      ticks(2); chk("R5 before match", {31'b0, irq}, 0);
      ticks(1); chk("R5 match raises irq", {31'b0, irq}, 1);
      wr(cmp_a(i), c); chk("R6 clear by write", {31'b0, irq}, 0);
      repeat (4) @(negedge clk);
      chk("R8 still equal no refire", {31'b0, irq}, 0);
      wr(A_LOAD, c); repeat (2) @(negedge clk);
      chk("R8 preload equal no fire", {31'b0, irq}, 0);
    end
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(cmp_a(0), 2000); wr(A_LOAD, 1999);
    wr(A_CTRL, 32'h0000_0100); ticks(1);
    chk("R3 no fire", {31'b0, irq}, 0);
    rd(A_CNT, v); chk("R3 count held", v, 1999);
    wr(A_CTRL, 32'h0000_2000); ticks(1);
    chk("R4 no fire", {31'b0, irq}, 0);
    rd(A_CNT, v); chk("R4 count held", v, 1999);
    wr(A_CTRL, RUN_BOTH); ticks(1);
    chk("R5 fire after enable", {31'b0, irq}, 1);
    wr(cmp_a(0), 2000);
    chk("R6 cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(cmp_a(0), 5); wr(cmp_a(1), 5); wr(cmp_a(2), 0);
    wr(A_LOAD, 32'hFFFF_FFFE);
    ticks(1); chk("R9 no event at max", {31'b0, irq}, 0);
    rd(A_CNT, v); chk("R9 at max", v, 32'hFFFF_FFFF);
    ticks(1);
    rd(A_CNT, v); chk("R9 wrapped", v, 0);
    chk("R9 compare zero fires", {31'b0, irq}, 1);
    wr(cmp_a(2), 0); chk("R6 clear after wrap", {31'b0, irq}, 0);
    rd(8'h20, v); chk("R10 unmapped reads 0", v, 0);
  endtask

  initial begin
    rst_n = 0; tick_en = 0; bus_req = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_gating();
    t_count();
    t_match();
    t_stop();
    t_wrap();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule